// File: doc/BRIEF.md
# Link Self-Test Controller and Error Monitor

This block runs the receive-side self-test of a serial video link and reports how it went. A single control byte written by the host starts or stops the test. Bit 0 is the enable. Bits [2:1] choose the clock for the far-end serializer. Bits [7:6] decide whether the downstream video outputs stay on during the test. While the test runs, the block counts data errors reported for one selected receive port. It also emits a short active-low pass/fail pulse per port for each error, and forwards the selected port's lock state toward general-purpose pins.

The error count is an 8-bit value with two reserved meanings. Normal counting stops at 0xFE. The code 0xFF means the receiver never locked within a configurable window after start, or lost lock after having locked. The clock-source selection is captured only at the moment the test starts and is driven toward the far-end serializer. A status bit mirrors whether the far end reports its own test as active.

Top module: `link_bist_mon`

## Requirements
- R1: A write with bit 0 set starts the test, and a write with bit 0 clear stops it. `test_on` reflects the written bit from the first rising edge after the write edge onward.
- R2: The counter clears to 0x00 on the write that starts the test, that is, when bit 0 goes from 0 to 1. While running, it increments by one for each cycle in which the selected port is locked and flags an error. After the test stops it holds its value.
- R3: Normal counting saturates at 0xFE. Further errors leave the value at 0xFE.
- R4: If the selected port's lock drops after it was seen high during the current run, the count becomes 0xFF. It stays 0xFF until the next start, even if lock returns.
- R5: If the selected port is not locked in any of the first LOCK_WAIT running cycles after start, the count becomes 0xFF on the LOCK_WAIT-th running cycle.
- R6: `pass_n[p]` is high by default. It goes low for exactly one cycle, one edge after each cycle in which the test runs and port p is locked and flags an error. Errors on an unlocked port are ignored, both by `pass_n` and by the counter.
- R7: `lock_out` is the lock input of the port chosen by `port_sel`, registered once.
- R8: `out_en` is 1 when the test is off. While the test runs, it is 1 only when bits [7:6] equal 2'b10 and is 0 for any other value. It updates together with `test_on`.
- R9: `csi_lp11` is high, one edge after the condition, whenever the test runs and not both of the following hold: outputs are enabled (mode 2'b10) and `pat_en` is high.
- R10: `ser_clk_src` takes bits [2:1] only on a start write. Writes during a run leave it unchanged. `ser_int_clk` is 1 when that latched value is nonzero (0 selects the external clock).
- R11: `far_active_sts` is `far_test_active` registered once.
- R12: Errors flagged on ports other than the selected one never change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte: [0] enable, [2:1] clock source, [7:6] output mode |
| port_sel | input | SEL_W | Receive port monitored by the counter and lock output |
| rx_lock | input | NUM_PORTS | Per-port receiver lock |
| rx_err | input | NUM_PORTS | Per-port data error strobe |
| pat_en | input | 1 | External pattern source is active |
| far_test_active | input | 1 | Far-end serializer reports its test active |
| test_on | output | 1 | Test running |
| err_count | output | 8 | Error count, 0xFE saturation, 0xFF lock failure |
| pass_n | output | NUM_PORTS | Per-port pass indication, low one cycle per error |
| lock_out | output | 1 | Registered lock of the selected port |
| out_en | output | 1 | Downstream video outputs enabled |
| csi_lp11 | output | 1 | Camera-serial output forced to LP11 idle |
| ser_clk_src | output | 2 | Clock source latched at test start |
| ser_int_clk | output | 1 | Latched clock source selects the internal clock |
| far_active_sts | output | 1 | Registered far-end test-active status |

## Verification
The following outputs all move on the first rising edge after the inputs that cause them: `test_on`, `out_en`, `err_count`, `pass_n`, `lock_out`, `ser_clk_src` and `far_active_sts`. `csi_lp11` follows one edge later, because it is derived from the already registered run state. The bench advances its behavioural model on every rising edge, using the inputs that were held stable since the preceding falling edge. It compares every output 1 ns after that edge, so each result is checked in the cycle it is due. Directed checks on saturation, the lock-loss code, the lock timeout and non-selected-port errors are also sampled after that settle point.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  localparam int CNT_W    = 8;
  localparam int EN_BIT   = 0;
  localparam int SRC_LSB  = 1;
  localparam int MODE_LSB = 6;

  typedef logic [CNT_W-1:0] errcnt_t;

  localparam errcnt_t CNT_SAT  = 8'hFE;
  localparam errcnt_t CNT_FAIL = 8'hFF;
  localparam logic [1:0] OMODE_ON = 2'b10;
endpackage

// File: rtl/lbist_ctrl_reg.sv
module lbist_ctrl_reg
  import lbist_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       pat_en,
  output logic       run_q,
  output logic       start,
  output logic       out_en_q,
  output logic       lp11_q,
  output logic [1:0] clk_src_q
);
  logic [1:0] mode_q;
  logic       run_nx;
  logic [1:0] mode_nx;

  assign start   = cfg_we && cfg_wdata[EN_BIT] && !run_q;
  assign run_nx  = cfg_we ? cfg_wdata[EN_BIT] : run_q;
  assign mode_nx = cfg_we ? cfg_wdata[MODE_LSB +: 2] : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      mode_q    <= 2'b00;
      out_en_q  <= 1'b1;
      lp11_q    <= 1'b0;
      clk_src_q <= 2'b00;
    end else begin
      run_q    <= run_nx;
      mode_q   <= mode_nx;
      out_en_q <= !run_nx || (mode_nx == OMODE_ON);
      lp11_q   <= run_q && !((mode_q == OMODE_ON) && pat_en);
      if (start) clk_src_q <= cfg_wdata[SRC_LSB +: 2];
    end
  end

  // R10
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(clk_src_q));
  // R1
  run_follow_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (run_q == $past(cfg_wdata[EN_BIT])));
endmodule

// File: rtl/lbist_err_cnt.sv
module lbist_err_cnt
  import lbist_pkg::*;
#(
  parameter int LOCK_WAIT = 16
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    run,
  input  logic    lock_s,
  input  logic    err_s,
  output errcnt_t cnt_q
);
  localparam int WAIT_W = (LOCK_WAIT > 2) ? $clog2(LOCK_WAIT) : 1;
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(LOCK_WAIT - 1);

  logic              seen_q;
  logic [WAIT_W-1:0] wait_q;
  logic              fail_now;

  assign fail_now = !lock_s && (seen_q || (wait_q == WAIT_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      wait_q <= '0;
    end else if (start) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      wait_q <= '0;
    end else if (run) begin
      if (cnt_q != CNT_FAIL) begin
        if (fail_now) cnt_q <= CNT_FAIL;
        else if (lock_s && err_s && cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
      if (!seen_q && !lock_s && wait_q != WAIT_LAST) wait_q <= wait_q + 1'b1;
      if (lock_s) seen_q <= 1'b1;
    end
  end

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt_q == '0));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 8'd1 || cnt_q == CNT_FAIL));
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_FAIL && !start) |=> (cnt_q == CNT_FAIL));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/lbist_port_ind.sv
module lbist_port_ind #(
  parameter int NUM_PORTS = 4,
  parameter int SEL_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [SEL_W-1:0]     port_sel,
  input  logic [NUM_PORTS-1:0] rx_lock,
  input  logic [NUM_PORTS-1:0] rx_err,
  input  logic                 far_act,
  output logic [NUM_PORTS-1:0] pass_n_q,
  output logic                 lock_q,
  output logic                 far_q
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) pass_n_q[p] <= 1'b1;
      else     pass_n_q[p] <= !(run && rx_lock[p] && rx_err[p]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      far_q  <= 1'b0;
    end else begin
      lock_q <= rx_lock[port_sel];
      far_q  <= far_act;
    end
  end

  // R6
  idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pass_n_q == {NUM_PORTS{1'b1}}));
  // R6
  unlocked_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_lock == '0) |=> (pass_n_q == {NUM_PORTS{1'b1}}));
endmodule

// File: rtl/link_bist_mon.sv
module link_bist_mon
  import lbist_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int LOCK_WAIT = 16,
  localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_wdata,
  input  logic [SEL_W-1:0]     port_sel,
  input  logic [NUM_PORTS-1:0] rx_lock,
  input  logic [NUM_PORTS-1:0] rx_err,
  input  logic                 pat_en,
  input  logic                 far_test_active,
  output logic                 test_on,
  output logic [7:0]           err_count,
  output logic [NUM_PORTS-1:0] pass_n,
  output logic                 lock_out,
  output logic                 out_en,
  output logic                 csi_lp11,
  output logic [1:0]           ser_clk_src,
  output logic                 ser_int_clk,
  output logic                 far_active_sts
);
  logic    start;
  errcnt_t cnt;

  lbist_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .pat_en(pat_en),
    .run_q(test_on), .start(start), .out_en_q(out_en), .lp11_q(csi_lp11),
    .clk_src_q(ser_clk_src)
  );

  lbist_err_cnt #(.LOCK_WAIT(LOCK_WAIT)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .run(test_on),
    .lock_s(rx_lock[port_sel]), .err_s(rx_err[port_sel]), .cnt_q(cnt)
  );

  lbist_port_ind #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_ind (
    .clk(clk), .rst(rst), .run(test_on), .port_sel(port_sel),
    .rx_lock(rx_lock), .rx_err(rx_err), .far_act(far_test_active),
    .pass_n_q(pass_n), .lock_q(lock_out), .far_q(far_active_sts)
  );

  assign err_count   = cnt;
  assign ser_int_clk = |ser_clk_src;

  // R8
  idle_outen_chk: assert property (@(posedge clk) disable iff (rst)
    !test_on |-> out_en);
  // R9
  idle_lp11_chk: assert property (@(posedge clk) disable iff (rst)
    !test_on |=> (!csi_lp11 || $past(test_on) == 1'b0 && !csi_lp11 || $fell(test_on)));
endmodule

// File: tb/link_bist_mon_tb.sv
`timescale 1ns/100ps
module link_bist_mon_tb;
  localparam int NP = 4;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [1:0]    port_sel = '0;
  logic [NP-1:0] rx_lock = '0;
  logic [NP-1:0] rx_err = '0;
  logic          pat_en = 1'b0;
  logic          far_test_active = 1'b0;
  logic          test_on, lock_out, out_en, csi_lp11, ser_int_clk, far_active_sts;
  logic [7:0]    err_count;
  logic [NP-1:0] pass_n;
  logic [1:0]    ser_clk_src;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  link_bist_mon #(.NUM_PORTS(NP), .LOCK_WAIT(LW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .port_sel(port_sel),
    .rx_lock(rx_lock), .rx_err(rx_err), .pat_en(pat_en), .far_test_active(far_test_active),
    .test_on(test_on), .err_count(err_count), .pass_n(pass_n), .lock_out(lock_out),
    .out_en(out_en), .csi_lp11(csi_lp11), .ser_clk_src(ser_clk_src),
    .ser_int_clk(ser_int_clk), .far_active_sts(far_active_sts)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model state
  bit m_en, m_seen, m_lock, m_far, m_outen, m_lp11;
  int m_mode, m_src, m_cnt, m_wt;
  bit [NP-1:0] m_pass;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_seen = 0; m_lock = 0; m_far = 0; m_outen = 1; m_lp11 = 0;
      m_mode = 0; m_src = 0; m_cnt = 0; m_wt = 0; m_pass = '1;
    end else begin
      bit st, lk, er;
      st = cfg_we && cfg_wdata[0] && !m_en;
      lk = rx_lock[port_sel];
      er = rx_err[port_sel];
      m_lp11 = m_en && !(m_mode == 2 && pat_en);
      for (int p = 0; p < NP; p++) m_pass[p] = !(m_en && rx_lock[p] && rx_err[p]);
      m_lock = lk;
      m_far  = far_test_active;
      if (st) begin
        m_cnt = 0; m_seen = 0; m_wt = 0; m_src = cfg_wdata[2:1];
      end else if (m_en) begin
        if (m_cnt != 255) begin
          if (!lk && (m_seen || m_wt == LW - 1)) m_cnt = 255;
          else if (lk && er && m_cnt < 254) m_cnt++;
        end
        if (!m_seen && !lk && m_wt < LW - 1) m_wt++;
        if (lk) m_seen = 1;
      end
      if (cfg_we) begin
        m_en = cfg_wdata[0];
        m_mode = cfg_wdata[7:6];
      end
      m_outen = !m_en || m_mode == 2;
    end
    #1;
    if (!done) begin
      chk(test_on == m_en, "R1 test_on", test_on, m_en);
      chk(err_count == m_cnt, "R2 err_count", err_count, m_cnt);
      chk(pass_n == m_pass, "R6 pass_n", pass_n, m_pass);
      chk(lock_out == m_lock, "R7 lock_out", lock_out, m_lock);
      chk(out_en == m_outen, "R8 out_en", out_en, m_outen);
      chk(csi_lp11 == m_lp11, "R9 csi_lp11", csi_lp11, m_lp11);
      chk(ser_clk_src == m_src, "R10 ser_clk_src", ser_clk_src, m_src);
      chk(ser_int_clk == (m_src != 0), "R10 ser_int_clk", ser_int_clk, m_src != 0);
      chk(far_active_sts == m_far, "R11 far_active_sts", far_active_sts, m_far);
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic errs(input int n, input logic [NP-1:0] mask);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_err = mask;
      @(negedge clk); rx_err = '0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(err_count == 8'h00 && pass_n == '1 && out_en && !test_on, "R1 reset state",
        {err_count, pass_n}, 8'h0F);

    // start, clock source 2, outputs off, port 0 locked
    rx_lock = 4'b0011; far_test_active = 1'b1;
    wr(8'h05);
    chk(ser_int_clk == 1'b1 && ser_clk_src == 2'd2, "R10 latch at start", ser_clk_src, 2);
    chk(out_en == 1'b0, "R8 outputs gated", out_en, 0);
    errs(5, 4'b0001);
    chk(err_count == 8'd5, "R2 five errors", err_count, 5);
    errs(4, 4'b0010);
    chk(err_count == 8'd5, "R12 other port ignored", err_count, 5);
    errs(3, 4'b0100);
    chk(err_count == 8'd5 && pass_n == '1, "R6 unlocked port ignored", err_count, 5);
    @(negedge clk); rx_err = 4'b0011;
    @(posedge clk); #1;
    chk(pass_n == 4'b1100, "R6 pulse low", pass_n, 4'hC);
    @(negedge clk); rx_err = '0;
    @(posedge clk); #1;
    chk(pass_n == 4'b1111, "R6 pulse one cycle", pass_n, 4'hF);

    // rewrite during run: mode on, source change ignored
    wr(8'h83);
    chk(ser_clk_src == 2'd2, "R10 change ignored while running", ser_clk_src, 2);
    chk(out_en == 1'b1, "R8 outputs enabled", out_en, 1);
    @(negedge clk);
    chk(csi_lp11 == 1'b1, "R9 idle without pattern", csi_lp11, 1);
    pat_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(csi_lp11 == 1'b0, "R9 pattern active", csi_lp11, 0);
    pat_en = 1'b0;

    // stop: counter holds
    wr(8'h00);
    errs(3, 4'b0001);
    chk(err_count == 8'd6 && !test_on, "R2 holds after stop", err_count, 6);

    // restart on port 1, external clock, continuous errors to saturation
    port_sel = 2'd1;
    wr(8'h01);
    chk(err_count == 8'd0 && ser_int_clk == 1'b0, "R2 cleared on start", err_count, 0);
    @(negedge clk); rx_err = 4'b0010;
    repeat (300) @(negedge clk);
    rx_err = '0;
    chk(err_count == 8'hFE, "R3 saturation", err_count, 8'hFE);

    // lock loss
    @(negedge clk); rx_lock = 4'b0001;
    @(negedge clk); rx_lock = 4'b0011;
    repeat (3) @(negedge clk);
    chk(err_count == 8'hFF, "R4 lock lost sticky", err_count, 8'hFF);
    wr(8'h00);

    // never locks
    port_sel = 2'd3;
    wr(8'h07);
    repeat (LW - 4) @(negedge clk);
    chk(err_count == 8'h00, "R5 before window end", err_count, 0);
    repeat (6) @(negedge clk);
    chk(err_count == 8'hFF, "R5 lock timeout", err_count, 8'hFF);
    wr(8'h00);

    // late lock inside the window
    far_test_active = 1'b0;
    wr(8'h01);
    repeat (LW - 6) @(negedge clk);
    rx_lock = 4'b1000;
    errs(7, 4'b1000);
    chk(err_count == 8'd7 && lock_out, "R5 late lock counts", err_count, 7);
    chk(far_active_sts == 1'b0, "R11 far status", far_active_sts, 0);
    wr(8'h00);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule